// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-up to a usable state without software help. While idle after reset, it holds clock enable low and drives a NOP command. When `start` is seen, it raises clock enable and waits through a wake-up interval. It then issues one command per step, in this fixed order: precharge-all, extended mode register load, mode register load with DLL reset, precharge-all again, two auto-refreshes, and a final mode register load that leaves the DLL alone. After the last wait it raises `done` and keeps it high until the next reset.

Every command occupies exactly one clock cycle. A wait whose length is a parameter, counted in clock cycles, follows each command, and the block drives NOP with zero bank and address throughout every wait. The mode register values select burst length 4 and CAS latency 3. A build-time parameter changes them to CAS latency 2.5. Calibration, periodic refresh and normal traffic belong to other blocks, which start work once `done` is high.

The interface is plain control: `start` is a level input sampled at the clock edge, and the command pins feed the memory PHY directly. There is no data stream, so there is no back-pressure.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until `start` is sampled high, `cke` is 0, `done` is 0, the command is NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), and `ba` and `addr` are 0.
- R2: `start` is sampled only while idle. Driving it high or low during the sequence or after `done` changes no output. A new run needs a reset.
- R3: In the cycle after `start` is sampled high, `cke` goes to 1. NOP with bank 0 and address 0 is then driven for 1+T_WAKE cycles before the first command.
- R4: Precharge-all is driven as `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `ba`=0 and `addr`=0x0400 (bit 10 set). It is issued as step 1 and again as step 4.
- R5: The extended mode register load is driven as all four command pins at 0, with `ba`=1 and `addr`=0x0000. It is issued as step 2.
- R6: The first mode register load is driven as all four command pins at 0, with `ba`=0 and `addr`=0x0132 (DLL reset, CAS latency 3, burst 4). It becomes 0x0162 when CL_HALF=1. It is issued as step 3.
- R7: The two auto-refreshes are driven as `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, with `ba`=0 and `addr`=0. They are issued as steps 5 and 6.
- R8: The final mode register load is driven as all four command pins at 0, with `ba`=0 and `addr`=0x0032. It becomes 0x0062 when CL_HALF=1. It is issued as step 7.
- R9: Each command lasts exactly one cycle. NOP with `ba`=0 and `addr`=0 follows it for exactly T_PRE cycles after a precharge, T_MRD after the extended load, T_MRS_LONG after each mode register load, and T_RFC after each refresh.
- R10: `done` rises in the cycle after the final wait ends and then stays 1, with `cke`=1 and NOP, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when sampled high while idle |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions assume that every wait parameter is at least 1 and that ADDR_W is at least 11, so that bit 10 exists. The bench uses legal values for these. The properties depend on no particular behaviour of `start`. The stimulus therefore drives `start` as a single pulse, holds it high for a whole run, toggles it during a run and after completion, and applies a reset partway through a run. Two instances, one for each CAS latency setting, are compared against a behavioural cycle model on every clock.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_DONE} phase_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] cmd_t;
  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_REF = 4'b0001;
  localparam cmd_t CMD_MRS = 4'b0000;

  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);
endpackage

// File: rtl/ddr_init_step_table.sv
module ddr_init_step_table
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter bit CL_HALF    = 1'b0,
  parameter int T_WAKE     = 4,
  parameter int T_PRE      = 2,
  parameter int T_MRD      = 2,
  parameter int T_MRS_LONG = 200,
  parameter int T_RFC      = 8,
  parameter int CNT_W      = 8
) (
  input  logic [STEP_W-1:0] step,
  output cmd_t              cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  wait_len
);
  localparam logic [12:0] MR_DLL_RST = CL_HALF ? 13'h0162 : 13'h0132;
  localparam logic [12:0] MR_RUN     = CL_HALF ? 13'h0062 : 13'h0032;
  localparam logic [12:0] A10_ALL    = 13'h0400;

  always_comb begin
    cmd      = CMD_NOP;
    ba       = '0;
    addr     = '0;
    wait_len = CNT_W'(T_WAKE);
    unique case (step)
      3'd0: wait_len = CNT_W'(T_WAKE);
      3'd1, 3'd4: begin
        cmd      = CMD_PRE;
        addr     = ADDR_W'(A10_ALL);
        wait_len = CNT_W'(T_PRE);
      end
      3'd2: begin
        cmd      = CMD_MRS;
        ba       = BA_W'(1);
        wait_len = CNT_W'(T_MRD);
      end
      3'd3: begin
        cmd      = CMD_MRS;
        addr     = ADDR_W'(MR_DLL_RST);
        wait_len = CNT_W'(T_MRS_LONG);
      end
      3'd5, 3'd6: begin
        cmd      = CMD_REF;
        wait_len = CNT_W'(T_RFC);
      end
      default: begin
        cmd      = CMD_MRS;
        addr     = ADDR_W'(MR_RUN);
        wait_len = CNT_W'(T_MRS_LONG);
      end
    endcase
  end
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R9
  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!expired && !load) |=> (count == $past(count) - 1'b1)); // R9
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter bit CL_HALF    = 1'b0,
  parameter int T_WAKE     = 4,
  parameter int T_PRE      = 2,
  parameter int T_MRD      = 2,
  parameter int T_MRS_LONG = 200,
  parameter int T_RFC      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int MAX_A    = (T_WAKE > T_PRE) ? T_WAKE : T_PRE;
  localparam int MAX_B    = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_WAIT = (MAX_C > T_MRS_LONG) ? MAX_C : T_MRS_LONG;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  phase_t              phase;
  logic [STEP_W-1:0]   step;
  cmd_t                tbl_cmd, cmd;
  logic [BA_W-1:0]     tbl_ba;
  logic [ADDR_W-1:0]   tbl_addr;
  logic [CNT_W-1:0]    tbl_wait;
  logic                wait_over;

  ddr_init_step_table #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CL_HALF(CL_HALF),
    .T_WAKE(T_WAKE), .T_PRE(T_PRE), .T_MRD(T_MRD),
    .T_MRS_LONG(T_MRS_LONG), .T_RFC(T_RFC), .CNT_W(CNT_W)
  ) u_table (
    .step(step), .cmd(tbl_cmd), .ba(tbl_ba), .addr(tbl_addr), .wait_len(tbl_wait)
  );

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(phase == PH_ISSUE),
    .load_val(tbl_wait - 1'b1),
    .expired(wait_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (start) begin
                    phase <= PH_ISSUE;
                    step  <= '0;
                  end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT:  if (wait_over) begin
                    if (step == LAST_STEP) phase <= PH_DONE;
                    else begin
                      phase <= PH_ISSUE;
                      step  <= step + 1'b1;
                    end
                  end
        default:  phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    cmd  = (phase == PH_ISSUE) ? tbl_cmd : CMD_NOP;
    ba   = (phase == PH_ISSUE) ? tbl_ba : '0;
    addr = (phase == PH_ISSUE) ? tbl_addr : '0;
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke  = (phase != PH_IDLE);
  assign done = (phase == PH_DONE);

  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R9
  AST_CKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |-> cke); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP && !done && addr == '0 && ba == '0)); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (addr[10] && ba == '0)); // R4
  AST_REF_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (addr == '0 && ba == '0)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cke && cmd == CMD_NOP)); // R10
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke); // R2
endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
  localparam int T_WAKE = 3, T_PRE = 2, T_MRD = 2, T_MRS_LONG = 12, T_RFC = 5;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0] ba_a, ba_b;
  logic [12:0] addr_a, addr_b;

  ddr_init_seq #(.CL_HALF(1'b0), .T_WAKE(T_WAKE), .T_PRE(T_PRE), .T_MRD(T_MRD),
    .T_MRS_LONG(T_MRS_LONG), .T_RFC(T_RFC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
    .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .done(done_a));

  ddr_init_seq #(.CL_HALF(1'b1), .T_WAKE(T_WAKE), .T_PRE(T_PRE), .T_MRD(T_MRD),
    .T_MRS_LONG(T_MRS_LONG), .T_RFC(T_RFC)) uut_half (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
    .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .done(done_b));

  // {done, cke, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[12:0]}
  wire [20:0] obs_a = {done_a, cke_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a};
  wire [20:0] obs_b = {done_b, cke_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b};

  int checks = 0, errors = 0, mode = 0;
  logic [20:0] exp_q[$];
  string tag_q[$];

  function automatic logic [20:0] pk(logic d, logic k, logic [3:0] c, logic [1:0] b, logic [12:0] a);
    return {d, k, c, b, a};
  endfunction

  function automatic logic [20:0] to_half(logic [20:0] v);
    logic [20:0] r = v;
    if (v[18:15] == MRS && v[14:13] == 2'd0) begin
      if (v[12:0] == 13'h0132) r[12:0] = 13'h0162;
      if (v[12:0] == 13'h0032) r[12:0] = 13'h0062;
    end
    return r;
  endfunction

  task automatic push_step(logic [3:0] c, logic [1:0] b, logic [12:0] a, int n, string t);
    exp_q.push_back(pk(1'b0, 1'b1, c, b, a));
    tag_q.push_back(t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pk(1'b0, 1'b1, NOP, 2'd0, 13'h0));
      tag_q.push_back("R9");
    end
  endtask

  task automatic build();
    exp_q.delete();
    tag_q.delete();
    push_step(NOP, 2'd0, 13'h0000, T_WAKE, "R3");
    push_step(PRE, 2'd0, 13'h0400, T_PRE, "R4");
    push_step(MRS, 2'd1, 13'h0000, T_MRD, "R5");
    push_step(MRS, 2'd0, 13'h0132, T_MRS_LONG, "R6");
    push_step(PRE, 2'd0, 13'h0400, T_PRE, "R4");
    push_step(REF, 2'd0, 13'h0000, T_RFC, "R7");
    push_step(REF, 2'd0, 13'h0000, T_RFC, "R7");
    push_step(MRS, 2'd0, 13'h0032, T_MRS_LONG, "R8");
  endtask

  task automatic check(logic [20:0] act, logic [20:0] exv, string t, string inst);
    checks++;
    if (act !== exv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, inst, act, exv, $time);
    end
  endtask

  task automatic cycle();
    logic s = start;
    logic r = rst_n;
    logic [20:0] e;
    string t;
    @(negedge clk);
    if (!r) begin
      mode = 0;
      exp_q.delete();
      tag_q.delete();
    end else if (mode == 0 && s) begin
      build();
      mode = 1;
    end else if (mode != 0 && s) begin
      t = "R2";
    end
    if (mode == 0) begin
      e = pk(1'b0, 1'b0, NOP, 2'd0, 13'h0);
      if (t == "") t = "R1";
    end else if (mode == 1) begin
      e = exp_q.pop_front();
      if (t == "") t = tag_q.pop_front(); else void'(tag_q.pop_front());
      if (exp_q.size() == 0) mode = 2;
    end else begin
      e = pk(1'b1, 1'b1, NOP, 2'd0, 13'h0);
      if (t == "") t = "R10";
    end
    check(obs_a, e, t, "cl3");
    check(obs_b, to_half(e), t, "cl2.5");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset and idle without start
    run(3);
    rst_n = 1'b1;
    run(5);
    // single-cycle start pulse, then start toggled mid-run (R2)
    start = 1'b1; cycle();
    start = 1'b0; run(10);
    start = 1'b1; run(2);
    start = 1'b0; run(80);
    // R10 / R2: start after done has no effect
    start = 1'b1; run(6);
    start = 1'b0; run(3);
    // level start held through a whole run
    rst_n = 1'b0; start = 1'b0; run(2);
    rst_n = 1'b1; run(2);
    start = 1'b1; run(90);
    // reset partway through a run, then restart
    start = 1'b0; rst_n = 1'b0; run(2);
    rst_n = 1'b1; start = 1'b1; run(15);
    rst_n = 1'b0; start = 1'b0; run(2);
    rst_n = 1'b1; run(3);
    start = 1'b1; cycle();
    start = 1'b0; run(85);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule